// File: doc/BRIEF.md
# Scrambled-Pattern Lane Bonding Controller

This block brings four independently skewed serial lanes from a four-bit sampler into a common bit alignment. Each lane carries one bit of every sample, so a lane never needs word or comma alignment of its own. The lanes can still arrive at the receiver a few bits apart. While the block bonds the lanes, it holds the sampler's data-enable output low and its test-pattern-enable output high. The lanes then carry only the scrambler sequence. Every word cycle the block scans one deserialized lane word for a fixed 32-bit marker.

Lane 0 is scanned first, and its marker offset becomes the reference. Lanes 1, 2 and 3 are then scanned in that order. A lane whose offset differs from the reference gets a one-cycle slip pulse. The block then waits a settling interval and scans that lane again. This repeats until the lane's offset equals the reference. Once every lane agrees, the block turns sample data back on, turns the test pattern off and reports lock. If a lane shows no marker for too long, the block raises an error flag and starts again from lane 0.

Top module: `lane_bond_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block drives `pat_en_o`=1, `data_en_o`=0, `locked_o`=0, `err_o`=0 and `slip_o`=0.
- R2: In each word cycle the block forms a 159-bit vector. Its upper 31 bits are bits [30:0] of the same lane's previous word, and its lower 128 bits are the current word. A marker at offset p (0..127) means bits [p+31:p] of this vector equal 0x30004000. When the marker occurs at more than one offset, the lowest offset counts.
- R3: Lane 0 is scanned first, and its marker offset is stored as the reference. Lanes 1, 2 and 3 are then scanned in increasing order. Each matching scan takes one word cycle.
- R4: A scan of lane k (k≥1) that finds the marker at an offset other than the reference produces a single one-cycle pulse on `slip_o[k]` in the next cycle. Bit 0 of `slip_o` never pulses. One pulse stands for a slip of one bit.
- R5: After a slip pulse the block waits `SETTLE_WORDS` word cycles and then scans the same lane again. Each slip therefore costs `SETTLE_WORDS`+2 cycles.
- R6: Every scan that finds no marker advances a miss counter. The counter clears when a scan finds the marker. If the `TIMEOUT_WORDS`-th consecutive scan also misses, `err_o` is set and scanning restarts at lane 0 on the next cycle. A marker found in that final scan counts as found.
- R7: When lane 3 matches the reference, the block enters the locked state in the next cycle. There it drives `locked_o`=1, `data_en_o`=1, `pat_en_o`=0 and `err_o`=0 until reset, and it issues no further slips.
- R8: At most one bit of `slip_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lanes_i | input | 512 | Four lane words, lane k in bits [128k+127:128k] |
| slip_o | output | 4 | One-bit slip request per lane |
| pat_en_o | output | 1 | Test pattern enable to the sampler |
| data_en_o | output | 1 | Sample data enable to the sampler |
| locked_o | output | 1 | All lanes aligned |
| err_o | output | 1 | A scan timed out since the last lock |

## Verification
Two things can happen in the same word cycle: the miss counter reaches its limit, and the marker shows up for the first time. The bench holds lane 0 at zero for a swept number of cycles around the timeout limit, so the marker first appears one cycle before, exactly at, or after the expiring scan. The error flag is then read in the limit cycle. A marker that arrives in the expiring scan must leave `err_o` low. A marker that arrives one cycle later must set it. In both cases the bench also checks the lock cycle that follows.

// File: rtl/lane_bond_pkg.sv
package lane_bond_pkg;

  typedef enum logic [1:0] {
    BOND_SCAN   = 2'd0,
    BOND_SLIP   = 2'd1,
    BOND_SETTLE = 2'd2,
    BOND_LOCKED = 2'd3
  } bond_state_e;

  localparam logic [31:0] BOND_MARKER = 32'h3000_4000;

endpackage

// File: rtl/lane_bond_carry.sv
module lane_bond_carry #(
  parameter int LANES   = 4,
  parameter int WORD_W  = 128,
  parameter int CARRY_W = 31
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES*WORD_W-1:0]   lanes_i,
  output logic [LANES*CARRY_W-1:0]  carry_o
);

  // Low bits of each lane's previous word, kept for markers that straddle words.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CARRY_W-1:0] carry_q;
    logic               carry_en;

    assign carry_en = 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        carry_q <= '0;
      end else if (carry_en) begin
        carry_q <= lanes_i[l*WORD_W +: CARRY_W];
      end
    end

    assign carry_o[l*CARRY_W +: CARRY_W] = carry_q;
  end

endmodule

// File: rtl/lane_bond_search.sv
module lane_bond_search #(
  parameter int          WORD_W = 128,
  parameter int          PAT_W  = 32,
  parameter logic [31:0] MARKER = 32'h3000_4000,
  localparam int         POS_W  = $clog2(WORD_W),
  localparam int         EXT_W  = WORD_W + PAT_W - 1
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic [PAT_W-2:0]   carry_i,
  output logic               hit_o,
  output logic [POS_W-1:0]   pos_o
);

  logic [EXT_W-1:0]  ext;
  logic [WORD_W-1:0] match;

  assign ext = {carry_i, word_i};

  for (genvar p = 0; p < WORD_W; p++) begin : g_win
    assign match[p] = (ext[p +: PAT_W] == MARKER[PAT_W-1:0]);
  end

  // Lowest matching offset wins.
  always_comb begin
    hit_o = 1'b0;
    pos_o = '0;
    for (int p = WORD_W - 1; p >= 0; p--) begin
      if (match[p]) begin
        hit_o = 1'b1;
        pos_o = POS_W'(p);
      end
    end
  end

endmodule

// File: rtl/lane_bond_fsm.sv
module lane_bond_fsm
  import lane_bond_pkg::*;
#(
  parameter int  LANES         = 4,
  parameter int  WORD_W        = 128,
  parameter int  SETTLE_WORDS  = 32,
  parameter int  TIMEOUT_WORDS = 1024,
  localparam int POS_W  = $clog2(WORD_W),
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int TMO_W  = $clog2(TIMEOUT_WORDS + 1),
  localparam int WAIT_W = $clog2(SETTLE_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic [LANE_W-1:0] lane_o,
  output logic [LANES-1:0]  slip_o,
  output logic              pat_en_o,
  output logic              data_en_o,
  output logic              locked_o,
  output logic              err_o
);

  bond_state_e       state_q, state_n;
  logic [LANE_W-1:0] lane_q, lane_n;
  logic [POS_W-1:0]  ref_q, ref_n;
  logic [TMO_W-1:0]  tmo_q, tmo_n;
  logic [WAIT_W-1:0] wait_q, wait_n;
  logic              err_q, err_n;
  logic              last_lane;
  logic              tmo_end;
  logic              wait_end;

  assign last_lane = (lane_q == LANE_W'(LANES - 1));
  assign tmo_end   = (tmo_q == TMO_W'(TIMEOUT_WORDS - 1));
  assign wait_end  = (wait_q == WAIT_W'(SETTLE_WORDS - 1));

  always_comb begin
    state_n = state_q;
    lane_n  = lane_q;
    ref_n   = ref_q;
    tmo_n   = tmo_q;
    wait_n  = wait_q;
    err_n   = err_q;
    unique case (state_q)
      BOND_SCAN: begin
        if (hit_i) begin
          tmo_n = '0;
          if (lane_q == '0) begin
            ref_n  = pos_i;
            lane_n = LANE_W'(1);
          end else if (pos_i == ref_q) begin
            if (last_lane) begin
              state_n = BOND_LOCKED;
              err_n   = 1'b0;
            end else begin
              lane_n = lane_q + 1'b1;
            end
          end else begin
            state_n = BOND_SLIP;
          end
        end else if (tmo_end) begin
          tmo_n  = '0;
          err_n  = 1'b1;
          lane_n = '0;
        end else begin
          tmo_n = tmo_q + 1'b1;
        end
      end
      BOND_SLIP: begin
        state_n = BOND_SETTLE;
        wait_n  = '0;
      end
      BOND_SETTLE: begin
        if (wait_end) begin
          state_n = BOND_SCAN;
        end else begin
          wait_n = wait_q + 1'b1;
        end
      end
      BOND_LOCKED: begin
        state_n = BOND_LOCKED;
      end
      default: begin
        state_n = BOND_SCAN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BOND_SCAN;
      lane_q  <= '0;
      ref_q   <= '0;
      tmo_q   <= '0;
      wait_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      lane_q  <= lane_n;
      ref_q   <= ref_n;
      tmo_q   <= tmo_n;
      wait_q  <= wait_n;
      err_q   <= err_n;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_slip
    assign slip_o[l] = (state_q == BOND_SLIP) && (lane_q == LANE_W'(l));
  end

  assign lane_o    = lane_q;
  assign locked_o  = (state_q == BOND_LOCKED);
  assign data_en_o = (state_q == BOND_LOCKED);
  assign pat_en_o  = (state_q != BOND_LOCKED);
  assign err_o     = err_q;

endmodule

// File: rtl/lane_bond_top.sv
module lane_bond_top
  import lane_bond_pkg::*;
#(
  parameter int  LANES         = 4,
  parameter int  WORD_W        = 128,
  parameter int  PAT_W         = 32,
  parameter int  SETTLE_WORDS  = 32,
  parameter int  TIMEOUT_WORDS = 1024,
  localparam int POS_W   = $clog2(WORD_W),
  localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CARRY_W = PAT_W - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*WORD_W-1:0] lanes_i,
  output logic [LANES-1:0]        slip_o,
  output logic                    pat_en_o,
  output logic                    data_en_o,
  output logic                    locked_o,
  output logic                    err_o
);

  logic [LANES*CARRY_W-1:0] carry_all;
  logic [LANE_W-1:0]        lane_sel;
  logic [WORD_W-1:0]        cur_word;
  logic [CARRY_W-1:0]       cur_carry;
  logic                     hit;
  logic [POS_W-1:0]         pos;

  lane_bond_carry #(
    .LANES   (LANES),
    .WORD_W  (WORD_W),
    .CARRY_W (CARRY_W)
  ) carry_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .lanes_i (lanes_i),
    .carry_o (carry_all)
  );

  // One shared scanner, steered to the lane under test.
  always_comb begin
    cur_word  = lanes_i[int'(lane_sel)*WORD_W +: WORD_W];
    cur_carry = carry_all[int'(lane_sel)*CARRY_W +: CARRY_W];
  end

  lane_bond_search #(
    .WORD_W (WORD_W),
    .PAT_W  (PAT_W),
    .MARKER (BOND_MARKER)
  ) search_i (
    .word_i  (cur_word),
    .carry_i (cur_carry),
    .hit_o   (hit),
    .pos_o   (pos)
  );

  lane_bond_fsm #(
    .LANES         (LANES),
    .WORD_W        (WORD_W),
    .SETTLE_WORDS  (SETTLE_WORDS),
    .TIMEOUT_WORDS (TIMEOUT_WORDS)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (hit),
    .pos_i     (pos),
    .lane_o    (lane_sel),
    .slip_o    (slip_o),
    .pat_en_o  (pat_en_o),
    .data_en_o (data_en_o),
    .locked_o  (locked_o),
    .err_o     (err_o)
  );

endmodule

// File: rtl/lane_bond_checker.sv
module lane_bond_checker #(
  parameter int  LANES        = 4,
  parameter int  SETTLE_WORDS = 32,
  localparam int GAP_W        = $clog2(SETTLE_WORDS + 2) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] slip_o,
  input logic             pat_en_o,
  input logic             data_en_o,
  input logic             locked_o,
  input logic             err_o
);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (slip_o != '0) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GAP_W'(SETTLE_WORDS + 1)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_SLIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slip_o)); // R8

  AST_REF_LANE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !slip_o[0]); // R4

  AST_SLIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_o != '0) |=> (slip_o == '0)); // R4

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((slip_o != '0) && seen_q) |-> (gap_q >= GAP_W'(SETTLE_WORDS + 1))); // R5

  AST_ENABLES_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en_o == locked_o) && (pat_en_o == !locked_o)); // R7

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o); // R7

  AST_LOCK_NO_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> (slip_o == '0)); // R7

  AST_LOCK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> !err_o); // R6

endmodule

bind lane_bond_top lane_bond_checker #(
  .LANES        (LANES),
  .SETTLE_WORDS (SETTLE_WORDS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .slip_o    (slip_o),
  .pat_en_o  (pat_en_o),
  .data_en_o (data_en_o),
  .locked_o  (locked_o),
  .err_o     (err_o)
);

// File: tb/lane_bond_top_tb_top.sv
`timescale 1ns/1ps
module lane_bond_top_tb_top;

  localparam int W    = 128;
  localparam int PW   = 32;
  localparam int NL   = 4;
  localparam int S    = 4;
  localparam int T    = 16;
  localparam logic [31:0] MK = 32'h3000_4000;

  logic              clk;
  logic              rst_n;
  logic [NL*W-1:0]   lanes;
  logic [NL-1:0]     slip;
  logic              pat_en, data_en, locked, err;

  int n_checks = 0;
  int n_fail   = 0;

  logic [W-1:0] frame;
  int  dly   [NL];
  int  zeros [NL];
  int  nslip [NL];
  int  ncnt;
  int  cyc;
  int  lock_cyc;
  logic errlog [0:127];

  lane_bond_top #(
    .LANES(NL), .WORD_W(W), .PAT_W(PW), .SETTLE_WORDS(S), .TIMEOUT_WORDS(T)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .lanes_i(lanes), .slip_o(slip),
    .pat_en_o(pat_en), .data_en_o(data_en), .locked_o(locked), .err_o(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] f, input int d);
    if (d == 0) return f;
    return (f << d) | (f >> (W - d));
  endfunction

  function automatic int lowpos(input logic [W-1:0] w);
    logic [W+PW-2:0] ext;
    ext = {w[PW-2:0], w};
    for (int p = 0; p < W; p++) if (ext[p +: PW] == MK) return p;
    return -1;
  endfunction

  function automatic int need_slips(input logic [W-1:0] f, input int dref, input int dk);
    int rp, d, n;
    rp = lowpos(rotl(f, dref));
    d = dk; n = 0;
    while (lowpos(rotl(f, d)) != rp && n < W) begin d = (d + 1) % W; n++; end
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc++;

  always @(negedge clk) begin
    if (!rst_n) ncnt = 0;
    else begin
      for (int k = 0; k < NL; k++) if (slip[k]) begin dly[k] = (dly[k] + 1) % W; nslip[k]++; end
      if (cyc < 128) errlog[cyc] = err;
      if (locked && lock_cyc < 0) lock_cyc = cyc;
    end
    for (int k = 0; k < NL; k++)
      lanes[k*W +: W] = (ncnt < zeros[k]) ? '0 : rotl(frame, dly[k]);
    if (rst_n) ncnt++;
  end

  task automatic bond(input logic [W-1:0] f, input int d0, input int d1, input int d2,
                      input int d3, input int z0, input int z2);
    frame = f;
    dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
    zeros[0] = z0; zeros[1] = 0; zeros[2] = z2; zeros[3] = 0;
    for (int k = 0; k < NL; k++) nslip[k] = 0;
    for (int i = 0; i < 128; i++) errlog[i] = 1'b0;
    lock_cyc = -1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cyc = 0;
    // R1 reset state
    check(pat_en && !data_en && !locked && !err && slip == '0, "R1",
          {slip, pat_en, data_en, locked, err}, 4'b1000);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(pat_en && !data_en && !locked && !err, "R1", {pat_en, data_en, locked, err}, 8);
    for (int i = 0; i < 20000 && lock_cyc < 0; i++) @(negedge clk);
  endtask

  task automatic aligned_run(input logic [W-1:0] f, input int d1, input int d2, input int d3);
    int n[NL];
    int exp_lock;
    n[0] = 0;
    n[1] = need_slips(f, 0, d1);
    n[2] = need_slips(f, 0, d2);
    n[3] = need_slips(f, 0, d3);
    exp_lock = 1;
    for (int k = 1; k < NL; k++) exp_lock += n[k] * (S + 2) + 1;
    bond(f, 0, d1, d2, d3, 0, 0);
    check(nslip[0] == 0, "R4 lane0 slips", nslip[0], 0);
    for (int k = 1; k < NL; k++)
      check(nslip[k] == n[k], "R2/R4 slips per lane", nslip[k], n[k]);
    check(lock_cyc == exp_lock, "R3/R5 lock cycle", lock_cyc, exp_lock);
    check(locked && data_en && !pat_en && !err, "R7 locked outputs",
          {locked, data_en, pat_en, err}, 4'b1100);
    for (int k = 1; k < NL; k++)
      check(lowpos(rotl(f, dly[k])) == lowpos(f), "R7 lanes aligned",
            lowpos(rotl(f, dly[k])), lowpos(f));
    repeat (10) @(negedge clk);
    check(locked && slip == '0 && nslip[1] == n[1], "R7 lock holds", nslip[1], n[1]);
  endtask

  logic [W-1:0] f1, f2;

  initial begin
    rst_n = 1'b0; lanes = '0; cyc = 0; ncnt = 0;
    for (int k = 0; k < NL; k++) begin dly[k] = 0; zeros[k] = 0; nslip[k] = 0; end
    f1 = '0; f1[5 +: PW] = MK;
    f2 = '0; f2[10 +: PW] = MK; f2[70 +: PW] = MK;

    aligned_run(f1, 0, 0, 0);
    aligned_run(f1, 3, 100, 127);
    aligned_run(f1, 1, 64, 96);
    aligned_run(f2, 20, 61, 90);   // R2 two markers, lowest offset counts
    aligned_run(f2, 127, 50, 5);

    // R6 timeout vs first marker in the same cycle
    for (int m = T - 2; m <= T + 1; m++) begin
      bond(f1, 0, 0, 0, 0, m, 0);
      check(errlog[T-1] == 1'b0, "R6 no early error", errlog[T-1], 0);
      check(errlog[T] == (m >= T), "R6 error at limit", errlog[T], (m >= T));
      check(lock_cyc == m + 1 + 3, "R6 lock after restart", lock_cyc, m + 4);
      check(!err && locked, "R7 error cleared on lock", err, 0);
    end

    // R6 lane 2 silent across two timeouts, restart from lane 0
    bond(f1, 0, 0, 0, 0, 0, 40);
    check(errlog[2 + T - 1] == 1'b0, "R6 lane2 before limit", errlog[2 + T - 1], 0);
    check(errlog[2 + T] == 1'b1, "R6 lane2 timeout", errlog[2 + T], 1);
    check(lock_cyc == 42, "R3/R6 restart lock cycle", lock_cyc, 42);
    check(!err, "R7 err cleared", err, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule